// File: doc/BRIEF.md
# Dual-Byte Interrupt Collector with Vector Readout

This block gathers sixteen interrupt sources into pending bits and merges them into one interrupt request. A source becomes pending when its request input rises. Sources 7:0 form the low half and sources 15:8 the high half. Each half has a byte-wide register port with two registers. The first is an acknowledge register: a write clears all pending bits of that half. The second is a mask register. Software writes it active-low, so a 1 in the written byte disables that source.

Two read-only registers support interrupt dispatch. The vector register returns the index of the lowest-numbered source that is both pending and enabled. The status register scans a separate 15-line interrupt bus and returns an encoded index for the first asserted line. Register access is a plain single-cycle write strobe with a combinational read. No stream data passes through the block, so no valid/ready handshake is used.

Top module: `irq_collector`

## Requirements
- R1: After reset the enable word is 0xFFFF, no source is pending, and `irq_out` is low.
- R2: A 0-to-1 transition on `src_req[i]` makes source i pending at the next clock edge. A request held high does not become pending again after it is acknowledged.
- R3: A write to address 1 stores the bitwise inverse of `reg_wdata` into enable bits 7:0. A write to address 3 does the same for enable bits 15:8. The other half is unchanged in both cases.
- R4: A read of address 1 or address 3 returns the full 16-bit enable word.
- R5: A write to address 0 clears pending bits 7:0 only. A write to address 2 clears pending bits 15:8 only.
- R6: A read of address 4 returns the index of the lowest set bit of (pending AND enable), or 0 when no bit is set. Disabled pending sources do not appear in this value.
- R7: A read of address 5 returns (j+1)*4, where j is the lowest asserted bit of `line_bus[14:0]`. It returns 0 when no line is asserted.
- R8: `irq_out` is high exactly when (pending AND enable) is nonzero. A source therefore raises `irq_out` one clock after its request rises, provided it is enabled.
- R9: If a request rises in the same cycle as an acknowledge write covering that source, the source ends up pending.
- R10: Reads of addresses 0, 2, 6 and 7 return 0. Writes to addresses 4 to 7 change neither the enable word nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 16 | Interrupt request inputs; a rising level makes the source pending |
| line_bus | input | 15 | Separate interrupt lines scanned by the status register |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The vector readout is exercised with several kinds of pending pattern:
- a single source in each half, which shows the index is encoded correctly;
- several sources pending together, which shows the lowest one wins over higher ones;
- a low source masked off while a high one is pending, which shows masked bits are skipped.

The status readout is driven with no line, with only line 0, with only line 14, and with several lines together. These patterns separate the zero case from the offset-by-one encoding and check the scan order.

The acknowledge tests load both halves before each acknowledge write, so a clear of the wrong half shows up. A same-cycle request and acknowledge confirms that the new request survives.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC   = 16;
  localparam int N_LINES = 15;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    ADR_ACK_LO  = 3'd0,
    ADR_MASK_LO = 3'd1,
    ADR_ACK_HI  = 3'd2,
    ADR_MASK_HI = 3'd3,
    ADR_VECTOR  = 3'd4,
    ADR_STATUS  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan from the top down so that the lowest set bit is the last one assigned.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) a_found_bit_set: assert (vec[idx]);
    else       a_none_zero: assert (vec == '0);
  end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pending
);
  logic [N-1:0] src_q;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign rise[g] = src_req[g] & ~src_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[g]   <= 1'b0;
        pending[g] <= 1'b0;
      end else begin
        src_q[g]   <= src_req[g];
        // A new rising request takes precedence over a clear in the same cycle.
        pending[g] <= rise[g] | (pending[g] & ~clr[g]);
      end
    end

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> pending[g]);
    p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !rise[g]) |=> !pending[g]);
    p_request_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && rise[g]) |=> pending[g]);
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int N = 16,
  localparam int H = N / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [H-1:0] wdata,
  output logic [N-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '1;
    end else begin
      if (wr_lo) enable[H-1:0] <= ~wdata;
      if (wr_hi) enable[N-1:H] <= ~wdata;
    end
  end

  p_mask_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (enable[H-1:0] == ~$past(wdata)) &&
                          (enable[N-1:H] == $past(enable[N-1:H])));
  p_mask_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (enable[N-1:H] == ~$past(wdata)) &&
                          (enable[H-1:0] == $past(enable[H-1:0])));
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> $stable(enable));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NL = N_LINES,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_req,
  input  logic [NL-1:0] line_bus,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_out
);
  localparam int H   = NS / 2;
  localparam int SIW = $clog2(NS);
  localparam int LIW = $clog2(NL);

  logic [NS-1:0]  pending, enable, active, clr;
  logic           wr_ack_lo, wr_ack_hi, wr_mask_lo, wr_mask_hi;
  logic           vec_found, line_found;
  logic [SIW-1:0] vec_idx;
  logic [LIW-1:0] line_idx;
  logic [DW-1:0]  status_val;

  assign wr_ack_lo  = reg_wr && (reg_addr == ADR_ACK_LO);
  assign wr_ack_hi  = reg_wr && (reg_addr == ADR_ACK_HI);
  assign wr_mask_lo = reg_wr && (reg_addr == ADR_MASK_LO);
  assign wr_mask_hi = reg_wr && (reg_addr == ADR_MASK_HI);
  assign clr        = {{H{wr_ack_hi}}, {H{wr_ack_lo}}};

  irq_pending_bank #(.N(NS)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .clr(clr), .pending(pending)
  );

  irq_mask_regs #(.N(NS)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_mask_lo), .wr_hi(wr_mask_hi),
    .wdata(reg_wdata[H-1:0]), .enable(enable)
  );

  assign active = pending & enable;

  irq_lowest_find #(.W(NS), .IW(SIW)) u_vec (
    .vec(active), .found(vec_found), .idx(vec_idx)
  );

  irq_lowest_find #(.W(NL), .IW(LIW)) u_line (
    .vec(line_bus), .found(line_found), .idx(line_idx)
  );

  assign status_val = line_found ? ((DW'(line_idx) + DW'(1)) << 2) : '0;
  assign irq_out    = vec_found;

  always_comb begin
    unique case (reg_addr)
      ADR_MASK_LO, ADR_MASK_HI: reg_rdata = DW'(enable);
      ADR_VECTOR:               reg_rdata = DW'(vec_idx);
      ADR_STATUS:               reg_rdata = status_val;
      default:                  reg_rdata = '0;
    endcase
  end

  p_vector_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADR_VECTOR) && !irq_out) |-> (reg_rdata == '0));
  p_status_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADR_STATUS) && (line_bus == '0)) |-> (reg_rdata == '0));
  p_status_line0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADR_STATUS) && line_bus[0]) |-> (reg_rdata == DW'(4)));
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_req[0] && !$past(src_req[0]) && enable[0]) && !wr_mask_lo) |=> irq_out);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > AW'(ADR_STATUS)) |-> (reg_rdata == '0));
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_req;
  logic [14:0] line_bus;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector u_irq_collector (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .line_bus(line_bus),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // Raise selected requests, then drop all of them after the latching edge.
  task automatic pulse_src(input logic [15:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  task automatic clear_all();
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd3, 8'h00);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(3'd1, v); check("R1 enable after reset", v, 16'hFFFF);
    rd_reg(3'd4, v); check("R1 vector after reset", v, 16'h0000);
    check("R1 irq_out after reset", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_latch_and_vector();
    logic [15:0] v;
    pulse_src(16'h0020);
    check("R8 irq_out after request", {15'b0, irq_out}, 16'h0001);
    rd_reg(3'd4, v); check("R2 R6 single low source", v, 16'd5);
    pulse_src(16'h1000);
    rd_reg(3'd4, v); check("R6 lowest wins", v, 16'd5);
    wr_reg(3'd0, 8'h00);
    rd_reg(3'd4, v); check("R6 high source", v, 16'd12);
    pulse_src(16'h0014);
    rd_reg(3'd4, v); check("R6 lowest of several", v, 16'd2);
    clear_all();
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr_reg(3'd1, 8'h0F);
    rd_reg(3'd1, v); check("R3 R4 low mask write", v, 16'hFFF0);
    wr_reg(3'd3, 8'hA0);
    rd_reg(3'd3, v); check("R3 R4 high mask write", v, 16'h5FF0);
    rd_reg(3'd1, v); check("R4 low port reads full word", v, 16'h5FF0);
    pulse_src(16'h0208);
    rd_reg(3'd4, v); check("R6 masked low source skipped", v, 16'd9);
    wr_reg(3'd2, 8'h00);
    check("R8 irq low when only masked pending", {15'b0, irq_out}, 16'h0000);
    rd_reg(3'd4, v); check("R6 nothing enabled", v, 16'd0);
    wr_reg(3'd1, 8'h00);
    check("R8 unmask raises irq", {15'b0, irq_out}, 16'h0001);
    rd_reg(3'd4, v); check("R6 unmasked source shows", v, 16'd3);
    clear_all();
  endtask

  task automatic t_ack_halves();
    logic [15:0] v;
    pulse_src(16'h4002);
    wr_reg(3'd0, 8'h00);
    rd_reg(3'd4, v); check("R5 low ack keeps high", v, 16'd14);
    pulse_src(16'h0040);
    wr_reg(3'd2, 8'h00);
    rd_reg(3'd4, v); check("R5 high ack keeps low", v, 16'd6);
    wr_reg(3'd0, 8'h00);
    check("R5 all cleared", {15'b0, irq_out}, 16'h0000);
    // Held level: no re-latch after ack
    @(negedge clk); src_req = 16'h0001;
    @(negedge clk);
    wr_reg(3'd0, 8'h00);
    check("R2 held level not relatched", {15'b0, irq_out}, 16'h0000);
    src_req = '0;
    @(negedge clk);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    pulse_src(16'h0004);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; src_req = 16'h0020;
    @(negedge clk);
    reg_wr = 1'b0; src_req = '0;
    rd_reg(3'd4, v); check("R9 new request survives ack", v, 16'd5);
    clear_all();
  endtask

  task automatic t_status();
    logic [15:0] v;
    line_bus = '0;
    rd_reg(3'd5, v); check("R7 no line", v, 16'd0);
    line_bus = 15'h0001;
    rd_reg(3'd5, v); check("R7 line 0", v, 16'd4);
    line_bus = 15'h4000;
    rd_reg(3'd5, v); check("R7 line 14", v, 16'd60);
    line_bus = 15'h0A40;
    rd_reg(3'd5, v); check("R7 lowest of several", v, 16'd28);
    line_bus = '0;
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    pulse_src(16'h0100);
    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd5, 8'hFF);
    wr_reg(3'd6, 8'hFF);
    wr_reg(3'd7, 8'hFF);
    rd_reg(3'd1, v); check("R10 enable untouched", v, 16'hFFFF);
    rd_reg(3'd4, v); check("R10 pending untouched", v, 16'd8);
    rd_reg(3'd0, v); check("R10 read ack lo", v, 16'd0);
    rd_reg(3'd2, v); check("R10 read ack hi", v, 16'd0);
    rd_reg(3'd6, v); check("R10 read addr 6", v, 16'd0);
    rd_reg(3'd7, v); check("R10 read addr 7", v, 16'd0);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; src_req = '0; line_bus = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_and_vector();
    t_mask();
    t_ack_halves();
    t_collision();
    t_status();
    t_unmapped();
    done = 1;
    finish_run();
  end
endmodule